// File: doc/BRIEF.md
# Guarded Accumulator Barrel Shifter

This block shifts a 36-bit accumulator word, 32 data bits under 4 guard bits, by a count taken from a 16-bit operand. A two-bit kind select picks one of four shifts. Arithmetic right works across all 36 bits and copies the top bit into vacated positions. Logical right works only on the 32 data bits, fills with zeros and clears the guard bits. Logical left and arithmetic left both work across all 36 bits and fill with zeros. Arithmetic left lets data bits climb into the guard bits and never re-derives them from bit 31.

The surrounding datapath issues one request per cycle with a valid strobe. The request carries the source word, the count operand and a tag that says where the operand came from: an auxiliary register, an immediate, or the other accumulator. One clock edge later the block presents the destination word with a done flag. It also reports how many issue cycles that operand form costs, so the pipeline control can plan around it. Operand fetch, decode and stalls belong to the surrounding logic.

Top module: `acc_shifter`

## Requirements
- R1: While reset is held and after it is released, until the first request, out_valid is 0, out_acc is 0 and out_cycles is 0.
- R2: A request sampled with in_valid high at a rising edge appears on out_acc and out_cycles after that edge, with out_valid high for exactly that one cycle. out_valid is low in any cycle after an edge where in_valid was low.
- R3: Kind code 0 (arithmetic right) shifts all 36 bits right and fills every vacated upper position with the source's bit 35.
- R4: Kind code 1 (logical right) shifts only source bits 31:0 right with zero fill. Result bits 35:32 are always 0.
- R5: Kind code 3 (logical left) shifts all 36 bits left and fills vacated low positions with zeros.
- R6: Kind code 2 (arithmetic left) shifts all 36 bits left with zero fill. Data bits move into the guard bits unchanged, and the guard bits are not refilled from bit 31, so its result equals that of kind 3.
- R7: The count is in_amount[5:0]. Bits 15:6 of in_amount have no effect on the result.
- R8: A count of 36 or more yields pure fill for kinds 0, 2 and 3 (all copies of bit 35 for kind 0, all zeros otherwise). A count of 32 or more yields zero for kind 1.
- R9: out_cycles reports the cost of the operand form from in_src: code 0 (auxiliary register) gives 1, code 1 (immediate) gives 2, code 2 (other accumulator) gives 2, and the reserved code 3 is treated as a register and gives 1.
- R10: While in_valid is low, out_acc and out_cycles keep their last values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_kind | input | 2 | Shift kind: 0 arith right, 1 logical right, 2 arith left, 3 logical left |
| in_src | input | 2 | Operand origin: 0 register, 1 immediate, 2 accumulator, 3 reserved |
| in_acc | input | 36 | Source accumulator word |
| in_amount | input | 16 | Count operand; the low 6 bits are used |
| out_valid | output | 1 | Done flag for one cycle |
| out_acc | output | 36 | Destination accumulator word |
| out_cycles | output | 2 | Issue cycles the operand form costs |

## Verification
Two things can land in the same cycle. A count can exceed the working width of the chosen kind, and that kind can have its own fill rule, such as sign fill for arithmetic right or guard clearing for logical right. Whether the saturation path or the ordinary shift path wins then decides the result. The bench sweeps every count from 0 to 63 for every kind over source words with bit 35 and bit 31 set in different mixes, so counts of 32 to 35 for logical right and 36 to 63 for the others meet negative, guard-only and data-only operands. Each result is compared with a 64-bit arithmetic model written in the bench. Random upper operand bits and a rotating operand origin run alongside, so the cost report and the ignored operand bits are judged on the same requests.

// File: rtl/acc_shift_pkg.sv
package acc_shift_pkg;

  localparam int DATA_W  = 32;
  localparam int GUARD_W = 4;
  localparam int ACC_W   = DATA_W + GUARD_W;
  localparam int OPND_W  = 16;
  localparam int CNT_W   = 6;
  localparam int CYC_W   = 2;
  localparam int NKINDS  = 4;

  typedef logic [ACC_W-1:0]  acc_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [OPND_W-1:0] opnd_t;
  typedef logic [CYC_W-1:0]  cyc_t;

  typedef enum logic [1:0] {
    K_SRA = 2'd0,
    K_SRL = 2'd1,
    K_SLA = 2'd2,
    K_SLL = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    S_REG = 2'd0,
    S_IMM = 2'd1,
    S_ACC = 2'd2,
    S_RSV = 2'd3
  } src_e;

  // Arithmetic right across the full guarded word, sign taken from the top bit.
  function automatic acc_t sra_full(input acc_t a, input cnt_t c);
    acc_t r;
    if (int'(c) >= ACC_W) r = {ACC_W{a[ACC_W-1]}};
    else                  r = acc_t'($signed(a) >>> c);
    return r;
  endfunction

  // Logical right on the data part only; guard part cleared.
  function automatic acc_t srl_data(input acc_t a, input cnt_t c);
    logic [DATA_W-1:0] low;
    acc_t r;
    low = a[DATA_W-1:0];
    if (int'(c) >= DATA_W) r = '0;
    else                   r = {{GUARD_W{1'b0}}, low >> c};
    return r;
  endfunction

  // Logical left across the full guarded word.
  function automatic acc_t sll_full(input acc_t a, input cnt_t c);
    acc_t r;
    if (int'(c) >= ACC_W) r = '0;
    else                  r = a << c;
    return r;
  endfunction

  // Arithmetic left: data flows into the guard bits, which keep what arrives.
  function automatic acc_t sla_full(input acc_t a, input cnt_t c);
    acc_t r;
    r = sll_full(a, c);
    return r;
  endfunction

  function automatic cyc_t form_cost(input src_e s);
    cyc_t r;
    case (s)
      S_IMM:   r = cyc_t'(2);
      S_ACC:   r = cyc_t'(2);
      default: r = cyc_t'(1);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/acc_shift_amount.sv
module acc_shift_amount
  import acc_shift_pkg::*;
(
  input  opnd_t amount,
  output cnt_t  cnt,
  output logic  wide_over,
  output logic  narrow_over
);
  localparam int WIDE_LIM   = ACC_W;
  localparam int NARROW_LIM = DATA_W;

  assign cnt         = amount[CNT_W-1:0];
  assign wide_over   = (int'(cnt) >= WIDE_LIM);
  assign narrow_over = (int'(cnt) >= NARROW_LIM);
endmodule

// File: rtl/acc_shift_lane.sv
module acc_shift_lane
  import acc_shift_pkg::*;
#(
  parameter kind_e KIND = K_SRA
) (
  input  acc_t src,
  input  cnt_t cnt,
  output acc_t res
);
  generate
    if (KIND == K_SRA) begin : g_sra
      assign res = sra_full(src, cnt);
    end else if (KIND == K_SRL) begin : g_srl
      assign res = srl_data(src, cnt);
    end else if (KIND == K_SLA) begin : g_sla
      assign res = sla_full(src, cnt);
    end else begin : g_sll
      assign res = sll_full(src, cnt);
    end
  endgenerate
endmodule

// File: rtl/acc_shift_cost.sv
module acc_shift_cost
  import acc_shift_pkg::*;
(
  input  logic [1:0] src,
  output cyc_t       cycles
);
  assign cycles = form_cost(src_e'(src));
endmodule

// File: rtl/acc_shifter.sv
module acc_shifter
  import acc_shift_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [1:0]  in_kind,
  input  logic [1:0]  in_src,
  input  logic [35:0] in_acc,
  input  logic [15:0] in_amount,
  output logic        out_valid,
  output logic [35:0] out_acc,
  output logic [1:0]  out_cycles
);
  // Named internal events for the checker.
  cnt_t cnt_w;
  logic wide_over;
  logic narrow_over;
  acc_t lane_res [NKINDS];
  acc_t res_next;
  cyc_t cyc_next;

  acc_shift_amount u_amount (
    .amount     (in_amount),
    .cnt        (cnt_w),
    .wide_over  (wide_over),
    .narrow_over(narrow_over)
  );

  for (genvar k = 0; k < NKINDS; k++) begin : g_lane
    acc_shift_lane #(.KIND(kind_e'(k))) u_lane (
      .src(in_acc),
      .cnt(cnt_w),
      .res(lane_res[k])
    );
  end

  assign res_next = lane_res[in_kind];

  acc_shift_cost u_cost (
    .src   (in_src),
    .cycles(cyc_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_acc    <= '0;
      out_cycles <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_acc    <= res_next;
        out_cycles <= cyc_next;
      end
    end
  end
endmodule

// File: rtl/acc_shifter_chk.sv
module acc_shifter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  in_kind,
  input logic [1:0]  in_src,
  input logic [35:0] in_acc,
  input logic        wide_over,
  input logic        narrow_over,
  input logic        out_valid,
  input logic [35:0] out_acc,
  input logic [1:0]  out_cycles
);
  // R2
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R4
  guard_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 2'd1) |=> (out_acc[35:32] == 4'h0));

  // R8
  sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 2'd0 && wide_over) |=> (out_acc == {36{$past(in_acc[35])}}));

  // R8
  narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 2'd1 && narrow_over) |=> (out_acc == 36'h0));

  // R8
  left_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind[1] && wide_over) |=> (out_acc == 36'h0));

  // R9
  imm_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_src == 2'd1) |=> (out_cycles == 2'd2));

  // R9
  reg_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_src == 2'd0) |=> (out_cycles == 2'd1));

  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_acc) && $stable(out_cycles)));
endmodule

bind acc_shifter acc_shifter_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_kind    (in_kind),
  .in_src     (in_src),
  .in_acc     (in_acc),
  .wide_over  (wide_over),
  .narrow_over(narrow_over),
  .out_valid  (out_valid),
  .out_acc    (out_acc),
  .out_cycles (out_cycles)
);

// File: tb/test_acc_shifter.sv
`timescale 1ns/1ps
module test_acc_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_kind = '0;
  logic [1:0]  in_src = '0;
  logic [35:0] in_acc = '0;
  logic [15:0] in_amount = '0;
  logic        out_valid;
  logic [35:0] out_acc;
  logic [1:0]  out_cycles;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  acc_shifter i_acc_shifter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .in_src(in_src), .in_acc(in_acc), .in_amount(in_amount),
    .out_valid(out_valid), .out_acc(out_acc), .out_cycles(out_cycles)
  );

  // Reference: 64-bit arithmetic, written from the requirements.
  function automatic logic [35:0] model(input logic [1:0] k, input logic [35:0] a, input int c);
    logic signed [63:0] sx;
    logic [63:0] ux;
    case (k)
      2'd0: begin sx = {{28{a[35]}}, a}; sx = sx >>> c; return sx[35:0]; end   // R3
      2'd1: begin ux = {32'h0, a[31:0]}; ux = ux >> c; return ux[35:0]; end    // R4
      default: begin ux = {28'h0, a}; ux = ux << c; return ux[35:0]; end      // R5 R6
    endcase
  endfunction

  function automatic logic [1:0] cost(input logic [1:0] s);
    return (s == 2'd1 || s == 2'd2) ? 2'd2 : 2'd1;                           // R9
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] k, input logic [1:0] s, input logic [35:0] a,
                       input logic [15:0] amt, input string req);
    in_valid = 1'b1; in_kind = k; in_src = s; in_acc = a; in_amount = amt;
    @(negedge clk);
    check("R2 done", {63'h0, out_valid}, 64'h1);
    check(req, {28'h0, out_acc}, {28'h0, model(k, a, int'(amt[5:0]))});
    check("R9 cost", {62'h0, out_cycles}, {62'h0, cost(s)});
    in_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [35:0] pats [6];
    logic [35:0] last_acc;
    logic [1:0]  last_cyc;
    string req;
    pats[0] = 36'h8_0000_0001;
    pats[1] = 36'h0_8000_0000;
    pats[2] = 36'hF_FFFF_FFFF;
    pats[3] = 36'h7_5A5A_A5A5;
    pats[4] = {$urandom(7) % 16, 32'h0} | 36'($urandom);
    pats[5] = {4'h3, 32'($urandom)};

    repeat (3) @(negedge clk);
    check("R1 valid in reset", {63'h0, out_valid}, 64'h0);
    check("R1 acc in reset", {28'h0, out_acc}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", {63'h0, out_valid}, 64'h0);
    check("R1 acc after reset", {28'h0, out_acc}, 64'h0);
    check("R1 cycles after reset", {62'h0, out_cycles}, 64'h0);

    // Full sweep: every kind, every count, every pattern; random upper operand bits (R7).
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < 64; c++) begin
        for (int p = 0; p < 6; p++) begin
          case (k)
            0: req = (c >= 36) ? "R8 sra overrange" : "R3 sra";
            1: req = (c >= 32) ? "R8 srl overrange" : "R4 srl";
            2: req = (c >= 36) ? "R8 sla overrange" : "R6 sla";
            default: req = (c >= 36) ? "R8 sll overrange" : "R5 sll";
          endcase
          apply(2'(k), 2'((c + p) % 4), pats[p], {10'($urandom), 6'(c)}, req);
        end
      end
    end

    // R6: guard bits come from data, not re-sign-extended from bit 31.
    apply(2'd2, 2'd0, 36'h0_4000_0000, 16'd1, "R6 guard from data");
    check("R6 guard bits", {60'h0, out_acc[35:32]}, 64'h0);
    apply(2'd2, 2'd0, 36'h0_C000_0000, 16'd2, "R6 carry into guard");
    check("R6 guard pattern", {60'h0, out_acc[35:32]}, 64'h3);

    // R7: upper operand bits ignored for the same low count.
    apply(2'd0, 2'd1, 36'h9_1234_5678, 16'hFFC4, "R7 upper bits set");
    apply(2'd0, 2'd1, 36'h9_1234_5678, 16'h0004, "R7 upper bits clear");

    // R10: idle cycles with changing inputs leave the outputs unchanged.
    apply(2'd3, 2'd2, 36'h1_0F0F_0F0F, 16'd3, "R5 before hold");
    last_acc = out_acc;
    last_cyc = out_cycles;
    for (int i = 0; i < 8; i++) begin
      in_valid = 1'b0;
      in_kind = 2'($urandom); in_src = 2'($urandom);
      in_acc = {4'($urandom), 32'($urandom)}; in_amount = 16'($urandom);
      @(negedge clk);
      check("R2 idle done low", {63'h0, out_valid}, 64'h0);
      check("R10 hold acc", {28'h0, out_acc}, {28'h0, last_acc});
      check("R10 hold cycles", {62'h0, out_cycles}, {62'h0, last_cyc});
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule